// File: doc/BRIEF.md
# Mesh Spike Packet Router

This block is the packet switch for one tile in a two-dimensional grid of neuron cores. A spike packet carries four fields: a signed column offset, a signed row offset, the index of the target axon in the destination core, and an axon delay counted in time steps. The router moves each packet toward its destination one hop at a time. It resolves the column offset first and the row offset after that. A packet whose offsets are both zero is handed to the tile's own delivery port.

The tile's neurons also inject traffic through the router. When a firing event arrives, it carries the index of the neuron that fired. The router uses that index to read the neuron's entry from a small routing table held in the tile, and the entry becomes the new packet. An entry whose offsets are both zero never enters the mesh: it goes straight to the delivery port. A global tick input advances a time-step counter. At delivery, the axon index leaves the router together with the time step at which the spike takes effect.

All five sides use synchronous valid/ready handshakes. Every input has a small queue and pushes back when that queue is full, so a packet is never lost. Each output picks among its requesting inputs in round-robin order.

Top module: `spk_router`

## Requirements
- R1: After reset, no output presents a valid packet, every mesh input and the fire input report ready, and the time-step counter is zero.
- R2: A packet is encoded MSB first as {dx[4], dy[4], axon[6], delay[4]}, with dx and dy in two's complement. When dx is not zero, the packet leaves east (mesh port 1) if dx > 0, with dx reduced by one, and leaves west (mesh port 3) if dx < 0, with dx increased by one. dy, axon and delay pass through unchanged, whatever dy holds.
- R3: When dx is zero and dy is not zero, the packet leaves north (mesh port 0) with dy reduced by one if dy > 0, and leaves south (mesh port 2) with dy increased by one if dy < 0. A packet on the north or south output always has dx equal to zero.
- R4: A packet with dx and dy both zero appears on the delivery port. The delivery port shows its axon index and a target step equal to (current step + delay) mod 2^8. No mesh output is valid for that packet.
- R5: A firing event with neuron index k forms a packet from routing table entry k as that entry stands at fire time, and routes it by R2 to R4. The packet is visible on its output one clock after the event is accepted.
- R6: A firing event whose table entry has both offsets zero is delivered locally and raises no mesh output.
- R7: Each clock with the tick input high advances the step counter by one, wrapping modulo 2^8. The target step uses the counter value in the cycle of delivery.
- R8: While an output is valid and not accepted, it stays valid with the same packet contents (the delivery port keeps the same axon). An input whose queue (depth 2) is full deasserts ready. Every accepted packet leaves exactly once.
- R9: When several inputs wait for the same output, grants rotate: after input i is served, the next grant goes to the first requesting input above i, wrapping around.
- R10: A table write (write enable, neuron index, 18-bit entry in packet encoding) takes effect at the clock edge. Firing events accepted after that edge use the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Global time-step pulse |
| mesh_in_valid | input | 4 | Neighbour packet valid, index 0 N, 1 E, 2 S, 3 W |
| mesh_in_data | input | 4x18 | Neighbour packets |
| mesh_in_ready | output | 4 | Input queue can accept |
| mesh_out_valid | output | 4 | Outgoing packet valid per direction |
| mesh_out_data | output | 4x18 | Outgoing packets with updated offsets |
| mesh_out_ready | input | 4 | Neighbour accepts packet |
| fire_valid | input | 1 | Local neuron fired |
| fire_id | input | 4 | Index of firing neuron |
| fire_ready | output | 1 | Fire queue can accept |
| tbl_we | input | 1 | Routing table write enable |
| tbl_addr | input | 4 | Routing table index to write |
| tbl_wdata | input | 18 | Routing table entry |
| dlv_valid | output | 1 | Spike delivered to this core |
| dlv_axon | output | 6 | Target axon index |
| dlv_tick | output | 8 | Time step at which the spike applies |
| dlv_ready | input | 1 | Core accepts delivered spike |

## Verification
Suppose the router held a wrong direction decision for a queue head. The packet would then appear on the wrong output in the very cycle after it was accepted, and its offsets would move the wrong way. For that reason every vector checks every output at that cycle. A corrupted arbiter pointer or a grant that is not held shows up only under contention. The bench builds contention deliberately on the delivery port: it blocks the port, fills one queue, and then checks the exact order in which the three packets drain. A step counter that drifts shows up as a wrong target step on the next local delivery, including one taken across the wrap point.

// File: rtl/spk_pkg.sv
package spk_pkg;
  parameter int DXW   = 4;
  parameter int DYW   = 4;
  parameter int AXW   = 6;
  parameter int DLW   = 4;
  parameter int PKT_W = DXW + DYW + AXW + DLW;
  parameter int NPORT = 5;

  typedef enum logic [2:0] {
    P_NORTH = 3'd0, P_EAST = 3'd1, P_SOUTH = 3'd2, P_WEST = 3'd3, P_LOCAL = 3'd4
  } port_e;

  typedef struct packed {
    logic signed [DXW-1:0] dx;
    logic signed [DYW-1:0] dy;
    logic [AXW-1:0]        axon;
    logic [DLW-1:0]        delay;
  } spike_t;

  // Column offset is resolved before row offset.
  function automatic port_e route_dir(spike_t p);
    if (p.dx > 0)      return P_EAST;
    else if (p.dx < 0) return P_WEST;
    else if (p.dy > 0) return P_NORTH;
    else if (p.dy < 0) return P_SOUTH;
    else               return P_LOCAL;
  endfunction

  // One hop moves the active offset one step toward zero.
  function automatic spike_t hop(spike_t p, port_e d);
    spike_t q;
    q = p;
    case (d)
      P_EAST:  q.dx = p.dx - DXW'(1);
      P_WEST:  q.dx = p.dx + DXW'(1);
      P_NORTH: q.dy = p.dy - DYW'(1);
      P_SOUTH: q.dy = p.dy + DYW'(1);
      default: q = p;
    endcase
    return q;
  endfunction
endpackage

// File: rtl/spk_fifo.sv
module spk_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 2   // power of two
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  assign full  = (cnt == (AW+1)'(DEPTH));
  assign empty = (cnt == '0);
  assign rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (pop)  rp <= rp + AW'(1);
      case ({push, pop})
        2'b10:   cnt <= cnt + (AW+1)'(1);
        2'b01:   cnt <= cnt - (AW+1)'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/spk_rr_arb.sv
module spk_rr_arb #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         accept,
  output logic [N-1:0] gnt
);
  localparam int IW = $clog2(N);

  logic          hold_q;
  logic [N-1:0]  gnt_q, pick;
  logic [IW-1:0] last_q, gnt_idx;

  always_comb begin
    int idx;
    pick = '0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last_q) + k) % N;
      if (pick == '0 && req[idx]) pick[idx] = 1'b1;
    end
  end

  assign gnt = hold_q ? gnt_q : pick;

  always_comb begin
    gnt_idx = '0;
    for (int k = 0; k < N; k++) if (gnt[k]) gnt_idx = IW'(k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      gnt_q  <= '0;
      last_q <= IW'(N-1);
    end else begin
      hold_q <= (|gnt) & ~accept;
      gnt_q  <= gnt;
      if (accept) last_q <= gnt_idx;
    end
  end

  assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  assert_grant_to_requester_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
endmodule

// File: rtl/spk_nbr_table.sv
module spk_nbr_table #(
  parameter int ENTRIES = 16,
  parameter int W       = 18
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [$clog2(ENTRIES)-1:0] waddr,
  input  logic [W-1:0]               wdata,
  input  logic [$clog2(ENTRIES)-1:0] raddr,
  output logic [W-1:0]               rdata
);
  logic [W-1:0] ent [ENTRIES];

  assign rdata = ent[raddr];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                          ent[e] <= '0;
      else if (we && waddr == ($clog2(ENTRIES))'(e)) ent[e] <= wdata;
    end
  end
endmodule

// File: rtl/spk_router.sv
module spk_router #(
  parameter int NEURONS    = 16,
  parameter int FIFO_DEPTH = 2,
  parameter int TICK_W     = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                tick,
  input  logic [3:0]                          mesh_in_valid,
  input  logic [3:0][spk_pkg::PKT_W-1:0]      mesh_in_data,
  output logic [3:0]                          mesh_in_ready,
  output logic [3:0]                          mesh_out_valid,
  output logic [3:0][spk_pkg::PKT_W-1:0]      mesh_out_data,
  input  logic [3:0]                          mesh_out_ready,
  input  logic                                fire_valid,
  input  logic [$clog2(NEURONS)-1:0]          fire_id,
  output logic                                fire_ready,
  input  logic                                tbl_we,
  input  logic [$clog2(NEURONS)-1:0]          tbl_addr,
  input  logic [spk_pkg::PKT_W-1:0]           tbl_wdata,
  output logic                                dlv_valid,
  output logic [spk_pkg::AXW-1:0]             dlv_axon,
  output logic [TICK_W-1:0]                   dlv_tick,
  input  logic                                dlv_ready
);
  import spk_pkg::*;

  localparam int NIN   = NPORT;   // 4 mesh inputs + fire queue
  localparam int NOUT  = NPORT;   // 4 mesh outputs + delivery
  localparam int FIREQ = int'(P_LOCAL);

  logic [TICK_W-1:0]           tick_q;
  logic [PKT_W-1:0]            tbl_rdata;
  logic [NIN-1:0]              in_push, in_full, in_empty, in_pop;
  logic [NIN-1:0][PKT_W-1:0]   in_wdata, head_raw;
  spike_t                      head_pkt [NIN];
  port_e                       head_dir [NIN];
  logic [NOUT-1:0][NIN-1:0]    req_m, gnt_m;
  logic [NOUT-1:0]             out_ready, out_valid, out_accept;
  spike_t                      out_pkt  [NOUT];

  // step counter
  always_ff @(posedge clk) begin
    if (!rst_n)    tick_q <= '0;
    else if (tick) tick_q <= tick_q + TICK_W'(1);
  end

  spk_nbr_table #(.ENTRIES(NEURONS), .W(PKT_W)) tbl_i (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_wdata),
    .raddr(fire_id), .rdata(tbl_rdata)
  );

  // input queues
  for (genvar i = 0; i < NIN; i++) begin : g_in
    if (i < 4) begin : g_mesh
      assign in_push[i]  = mesh_in_valid[i] & ~in_full[i];
      assign in_wdata[i] = mesh_in_data[i];
      assign mesh_in_ready[i] = ~in_full[i];
    end else begin : g_fire
      assign in_push[i]  = fire_valid & ~in_full[i];
      assign in_wdata[i] = tbl_rdata;
      assign fire_ready  = ~in_full[i];
    end

    spk_fifo #(.W(PKT_W), .DEPTH(FIFO_DEPTH)) q_i (
      .clk(clk), .rst_n(rst_n), .push(in_push[i]), .wdata(in_wdata[i]),
      .pop(in_pop[i]), .rdata(head_raw[i]), .full(in_full[i]), .empty(in_empty[i])
    );

    assign head_pkt[i] = spike_t'(head_raw[i]);
    assign head_dir[i] = route_dir(head_pkt[i]);

    for (genvar o = 0; o < NOUT; o++) begin : g_req
      assign req_m[o][i] = ~in_empty[i] & (head_dir[i] == port_e'(3'(o)));
    end
  end

  // output arbitration and data selection
  for (genvar o = 0; o < NOUT; o++) begin : g_out
    if (o < 4) begin : g_mo
      assign out_ready[o]      = mesh_out_ready[o];
      assign mesh_out_valid[o] = out_valid[o];
      assign mesh_out_data[o]  = out_pkt[o];
    end else begin : g_lo
      assign out_ready[o] = dlv_ready;
    end

    spk_rr_arb #(.N(NIN)) arb_i (
      .clk(clk), .rst_n(rst_n), .req(req_m[o]), .accept(out_accept[o]), .gnt(gnt_m[o])
    );

    assign out_valid[o]  = |gnt_m[o];
    assign out_accept[o] = out_valid[o] & out_ready[o];

    always_comb begin
      spike_t sel;
      sel = '0;
      for (int i = 0; i < NIN; i++) if (gnt_m[o][i]) sel = head_pkt[i];
      out_pkt[o] = hop(sel, port_e'(3'(o)));
    end
  end

  always_comb begin
    for (int i = 0; i < NIN; i++) begin
      in_pop[i] = 1'b0;
      for (int o = 0; o < NOUT; o++) in_pop[i] = in_pop[i] | (gnt_m[o][i] & out_ready[o]);
    end
  end

  assign dlv_valid = out_valid[FIREQ];
  assign dlv_axon  = out_pkt[FIREQ].axon;
  assign dlv_tick  = tick_q + TICK_W'(out_pkt[FIREQ].delay);

  // checks
  spike_t mo_n, mo_s, mo_e, mo_w;
  assign mo_n = spike_t'(mesh_out_data[0]);
  assign mo_e = spike_t'(mesh_out_data[1]);
  assign mo_s = spike_t'(mesh_out_data[2]);
  assign mo_w = spike_t'(mesh_out_data[3]);

  assert_x_first_north_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mesh_out_valid[0] |-> mo_n.dx == '0);
  assert_x_first_south_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mesh_out_valid[2] |-> mo_s.dx == '0);
  assert_east_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mesh_out_valid[1] |-> mo_e.dx >= 0);
  assert_west_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mesh_out_valid[3] |-> mo_w.dx <= 0);
  assert_local_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> (out_pkt[FIREQ].dx == '0 && out_pkt[FIREQ].dy == '0));
  assert_dlv_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_axon));
  for (genvar o = 0; o < 4; o++) begin : g_chk
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mesh_out_valid[o] && !mesh_out_ready[o] |=> mesh_out_valid[o] && $stable(mesh_out_data[o]));
  end
endmodule

// File: tb/spk_router_tb.sv
module spk_router_tb_top;
  import spk_pkg::*;
  localparam int PW = PKT_W;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, tick;
  logic [3:0] mi_v, mi_r, mo_v, mo_r;
  logic [3:0][PW-1:0] mi_d, mo_d;
  logic fire_valid, fire_ready, tbl_we, dlv_valid, dlv_ready;
  logic [3:0] fire_id, tbl_addr;
  logic [PW-1:0] tbl_wdata;
  logic [5:0] dlv_axon;
  logic [7:0] dlv_tick;

  spk_router dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .mesh_in_valid(mi_v), .mesh_in_data(mi_d), .mesh_in_ready(mi_r),
    .mesh_out_valid(mo_v), .mesh_out_data(mo_d), .mesh_out_ready(mo_r),
    .fire_valid(fire_valid), .fire_id(fire_id), .fire_ready(fire_ready),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .dlv_valid(dlv_valid), .dlv_axon(dlv_axon), .dlv_tick(dlv_tick), .dlv_ready(dlv_ready)
  );

  int n_chk = 0, n_bad = 0;
  int tick_m = 0;

  // {in, dx, dy, axon, delay, exp_port, exp_dx, exp_dy}
  localparam logic [31:0] VEC [8] = '{
    {3'd3, 4'h2, 4'h1, 6'd5,  4'd3,  3'd1, 4'h1, 4'h1},
    {3'd0, 4'hD, 4'h0, 6'd17, 4'd0,  3'd3, 4'hE, 4'h0},
    {3'd2, 4'h0, 4'h2, 6'd40, 4'd9,  3'd0, 4'h0, 4'h1},
    {3'd1, 4'h0, 4'hF, 6'd63, 4'd1,  3'd2, 4'h0, 4'h0},
    {3'd3, 4'h0, 4'h0, 6'd22, 4'd6,  3'd4, 4'h0, 4'h0},
    {3'd0, 4'hF, 4'h5, 6'd7,  4'd2,  3'd3, 4'h0, 4'h5},
    {3'd2, 4'h7, 4'h8, 6'd11, 4'd15, 3'd1, 4'h6, 4'h8},
    {3'd1, 4'h0, 4'h8, 6'd30, 4'd4,  3'd2, 4'h0, 4'h9}
  };

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic send(int p, logic [PW-1:0] d);
    @(negedge clk);
    mi_v[p] = 1'b1; mi_d[p] = d;
    @(negedge clk);
    mi_v = '0;
  endtask

  task automatic fire(logic [3:0] id);
    @(negedge clk);
    fire_valid = 1'b1; fire_id = id;
    @(negedge clk);
    fire_valid = 1'b0;
  endtask

  task automatic wr_tbl(logic [3:0] a, logic [PW-1:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = a; tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      tick_m = (tick_m + 1) % 256;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [2:0] ep;
    logic [5:0] ord [3];
    rst_n = 0; tick = 0; mi_v = '0; mi_d = '0; mo_r = 4'hF;
    fire_valid = 0; fire_id = '0; tbl_we = 0; tbl_addr = '0; tbl_wdata = '0; dlv_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 mesh_out_valid", 32'(mo_v), 0);
    chk("R1 dlv_valid", 32'(dlv_valid), 0);
    chk("R1 ready", 32'({mi_r, fire_ready}), 32'h1F);

    // R2 R3 R4 vector walk
    for (int v = 0; v < 8; v++) begin
      send(int'(VEC[v][31:29]), VEC[v][28:11]);
      ep = VEC[v][10:8];
      if (ep == 3'd4) begin
        chk("R4 no mesh out", 32'(mo_v), 0);
        chk("R4 dlv_valid", 32'(dlv_valid), 1);
        chk("R4 axon", 32'(dlv_axon), 32'(VEC[v][20:15]));
        chk("R4 tick", 32'(dlv_tick), 32'((tick_m + int'(VEC[v][14:11])) % 256));
      end else begin
        chk("R2/R3 port", 32'(mo_v), 32'(4'b1 << ep));
        chk("R2/R3 data", 32'(mo_d[ep]), 32'({VEC[v][7:4], VEC[v][3:0], VEC[v][20:11]}));
        chk("R2/R3 no dlv", 32'(dlv_valid), 0);
      end
      @(negedge clk);
      chk("R8 drained once", 32'({mo_v, dlv_valid}), 0);
    end

    // R7 ticks and wrap
    ticks(3);
    send(3, {4'h0, 4'h0, 6'd12, 4'd5});
    chk("R7 tick target", 32'(dlv_tick), 32'(8));
    ticks(250);
    send(0, {4'h0, 4'h0, 6'd13, 4'd15});
    chk("R7 wrap target", 32'(dlv_tick), 32'((253 + 15) % 256));

    // R5 R10 R6 fire lookup
    wr_tbl(4'd3, {4'h1, 4'h0, 6'd9, 4'd2});
    wr_tbl(4'd5, {4'h0, 4'h0, 6'd33, 4'd7});
    fire(4'd3);
    chk("R5 fire east", 32'(mo_v), 32'b0010);
    chk("R5 fire data", 32'(mo_d[1]), 32'({4'h0, 4'h0, 6'd9, 4'd2}));
    @(negedge clk);
    fire(4'd5);
    chk("R6 no mesh", 32'(mo_v), 0);
    chk("R6 dlv axon", 32'(dlv_axon), 33);
    chk("R6 dlv tick", 32'(dlv_tick), 32'((tick_m + 7) % 256));
    @(negedge clk);
    wr_tbl(4'd3, {4'h0, 4'hE, 6'd44, 4'd1});
    fire(4'd3);
    chk("R10 new entry port", 32'(mo_v), 32'b0100);
    chk("R10 new entry data", 32'(mo_d[2]), 32'({4'h0, 4'hF, 6'd44, 4'd1}));
    @(negedge clk);

    // R8 R9 backpressure and rotation
    dlv_ready = 0;
    send(1, {4'h0, 4'h0, 6'd1, 4'd0});
    send(1, {4'h0, 4'h0, 6'd2, 4'd0});
    chk("R8 full ready low", 32'(mi_r[1]), 0);
    send(3, {4'h0, 4'h0, 6'd3, 4'd0});
    repeat (3) @(negedge clk);
    chk("R8 held valid", 32'(dlv_valid), 1);
    chk("R8 held axon", 32'(dlv_axon), 1);
    dlv_ready = 1;
    for (int k = 0; k < 3; k++) begin
      ord[k] = dlv_valid ? dlv_axon : 6'd0;
      @(negedge clk);
    end
    chk("R9 order 0", 32'(ord[0]), 1);
    chk("R9 order 1", 32'(ord[1]), 3);
    chk("R9 order 2", 32'(ord[2]), 2);
    chk("R8 all drained", 32'(dlv_valid), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule